// File: doc/BRIEF.md
# Multiphase Phase-Shedding Sequencer

This block manages the low-power mode of a four-phase buck regulator by taking phases out of service and bringing them back. It watches a decoded 8-bit voltage-code byte. When the byte asks for low-power operation, the block removes the upper phases one at a time until the configured number of phases is left. When the byte asks for normal operation, the removed phases come back, lowest first. Each phase is switched only at the moment its own PWM rising edge arrives, so a phase never changes state partway through a switching period. A programmable number of PWM periods separates successive steps.

A voltage-code change that arrives while low-power operation is requested is handled in three stages. The block first restores every phase. It then hands the new code to an external stepping unit through a request/done handshake. After the stepping unit reports completion, the block sheds phases again. The block also tells the DAC whether to keep its trim offset while low-power mode is requested, and it raises a busy flag while any work is outstanding.

Top module: `phase_shed_seq`

## Requirements
- R1: After reset, all four phases are enabled (`phase_en` = 4'b1111), and `busy` and `step_req` are low. `offset_en` is high. Bit i of `phase_en` controls phase i+1.
- R2: The number of phases kept in low-power mode is set by `cfg_keep`: 01 keeps 1, 10 keeps 2, 11 keeps 3 and 00 keeps 2. The kept phases are always the lowest-numbered ones. Phase 1 (bit 0) is never disabled.
- R3: When shedding with a non-zero gap, at most one phase changes per clock. Phases are removed in descending order, starting with phase 4 (bit 3).
- R4: A `phase_en` bit changes only at a clock edge where that phase's `pwm_rise` bit is high. This applies both to removing a phase and to restoring it.
- R5: With a non-zero gap, `cfg_gap` sets the wait between consecutive phase changes in `pwm_tick` pulses: 01 is 1, 10 is 2 and 11 is 4. The count of ticks between two consecutive changes is at least the gap value and at most one more than it.
- R6: With `cfg_gap` = 00, no order or gap applies. Every phase that has to change does so at its own next `pwm_rise`, so a complete shed or restore finishes within one PWM period.
- R7: On restore with a non-zero gap, removed phases return one at a time in ascending order, starting with the lowest-numbered removed phase.
- R8: A byte is taken when `vid_valid` is high. Bit 7 = 0 requests low-power mode and bit 7 = 1 requests normal mode. A change in bits 6:0 starts a voltage step: `step_req` rises with `step_vid` equal to the new code and stays high until `step_done`.
- R9: If a new code arrives with bit 7 = 0 while low-power mode is requested, all phases are restored first. `step_req` is high only while all four phases are enabled. After `step_done` the block sheds phases again down to the kept count.
- R10: `offset_en` is low only while low-power mode is in effect and `cfg_offset_off` is 1. Otherwise it is high.
- R11: `busy` is high from the clock after a request until the phase vector matches the target and no voltage step is pending.
- R12: A request in the opposite direction during a shed or restore reverses the sequence from the current phase state, and no further phases are removed after the reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_data | input | 8 | Decoded voltage-code byte; bit 7 is the active-low low-power request |
| vid_valid | input | 1 | Strobe marking `vid_data` as new |
| pwm_rise | input | 4 | One-clock pulse per phase at that phase's PWM rising edge |
| pwm_tick | input | 1 | One-clock pulse once per PWM period |
| cfg_keep | input | 2 | Phase count kept in low-power mode |
| cfg_gap | input | 2 | Gap between steps, in PWM periods |
| cfg_offset_off | input | 1 | Drops the DAC offset while low-power mode is in effect |
| step_done | input | 1 | Stepping unit has reached the new code |
| phase_en | output | 4 | Per-phase enable; 0 means tri-state |
| step_req | output | 1 | Request to step the voltage to `step_vid` |
| step_vid | output | 7 | Latched target voltage code |
| offset_en | output | 1 | Apply the DAC offset |
| busy | output | 1 | A sequence or a voltage step is outstanding |

## Verification
A wrong target mask or a lost pending-step flag shows up as the wrong final value of `phase_en`, or as a `step_req` that never rises. The bench sees either one after the sequence settles, within a few PWM periods. A broken gap counter or a wrong choice of the next phase does not change the final mask. It changes the order of the phase-change events, or the number of ticks between them, from the very next step onward. For that reason, every change of `phase_en` is logged together with its tick distance and its alignment to `pwm_rise`.

// File: rtl/psq_pkg.sv
package psq_pkg;
  // widest gap value is 4 periods
  localparam int unsigned MAX_GAP = 4;
  localparam int unsigned GAP_W   = $clog2(MAX_GAP + 1);

  // gap code -> number of PWM ticks to wait
  function automatic logic [GAP_W-1:0] gap_ticks(input logic [1:0] code);
    case (code)
      2'b00:   gap_ticks = GAP_W'(0);
      2'b01:   gap_ticks = GAP_W'(1);
      2'b10:   gap_ticks = GAP_W'(2);
      default: gap_ticks = GAP_W'(MAX_GAP);
    endcase
  endfunction

  // keep code -> number of phases kept in low-power mode (00 maps to 2)
  function automatic logic [1:0] keep_count(input logic [1:0] code);
    keep_count = (code == 2'b00) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/psq_req_ctrl.sv
module psq_req_ctrl #(
  parameter int unsigned VID_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W:0]   vid_data,
  input  logic             vid_valid,
  input  logic             all_on,
  input  logic             step_done,
  output logic             ps_goal,
  output logic             step_req,
  output logic             step_pend,
  output logic [VID_W-1:0] step_vid
);
  logic             ps_req_q;
  logic             pend_q;
  logic [VID_W-1:0] vid_q;
  logic             code_change;
  logic             step_ack;

  assign code_change = vid_valid && (vid_data[VID_W-1:0] != vid_q);
  assign step_ack    = step_req && step_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_req_q <= 1'b0;
      pend_q   <= 1'b0;
      vid_q    <= '0;
    end else begin
      if (vid_valid) ps_req_q <= ~vid_data[VID_W];
      if (code_change) begin
        vid_q  <= vid_data[VID_W-1:0];
        pend_q <= 1'b1;
      end else if (step_ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign ps_goal   = ps_req_q && !pend_q;
  assign step_req  = pend_q && all_on;
  assign step_pend = pend_q;
  assign step_vid  = vid_q;

  // R8
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_done) |=> step_req);
endmodule

// File: rtl/psq_gap_timer.sv
module psq_gap_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_gap,
  input  logic       pwm_tick,
  input  logic       step_evt,
  output logic       gap_ok,
  output logic       gap_zero
);
  import psq_pkg::*;

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (step_evt)                 cnt_q <= gap_ticks(cfg_gap);
    else if (pwm_tick && cnt_q != '0)  cnt_q <= cnt_q - GAP_W'(1);
  end

  assign gap_ok   = (cnt_q == '0);
  assign gap_zero = (cfg_gap == 2'b00);

  // R5
  gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= GAP_W'(MAX_GAP));
endmodule

// File: rtl/psq_phase_ctrl.sv
module psq_phase_ctrl #(
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] goal_mask,
  input  logic [NUM_PHASES-1:0] pwm_rise,
  input  logic                  gap_zero,
  input  logic                  gap_ok,
  output logic [NUM_PHASES-1:0] phase_en,
  output logic                  step_evt,
  output logic                  all_on
);
  localparam logic [NUM_PHASES-1:0] ALL = '1;

  logic [NUM_PHASES-1:0] en_q, add_set, shed_set, sel, change;

  function automatic logic [NUM_PHASES-1:0] pick_low(input logic [NUM_PHASES-1:0] v);
    pick_low = '0;
    for (int i = NUM_PHASES - 1; i >= 0; i--)
      if (v[i]) begin
        pick_low    = '0;
        pick_low[i] = 1'b1;
      end
  endfunction

  function automatic logic [NUM_PHASES-1:0] pick_high(input logic [NUM_PHASES-1:0] v);
    pick_high = '0;
    for (int i = 0; i < NUM_PHASES; i++)
      if (v[i]) begin
        pick_high    = '0;
        pick_high[i] = 1'b1;
      end
  endfunction

  always_comb begin
    add_set  = goal_mask & ~en_q;
    shed_set = en_q & ~goal_mask;
    sel      = '0;
    if (gap_zero)        sel = add_set | shed_set;
    else if (gap_ok) begin
      if (add_set != '0)       sel = pick_low(add_set);
      else if (shed_set != '0) sel = pick_high(shed_set);
    end
    change = sel & pwm_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= ALL;
    else        en_q <= en_q ^ change;
  end

  assign phase_en = en_q;
  assign step_evt = |change;
  assign all_on   = (en_q == ALL);

  generate
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_align
      // R4
      pwm_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q[g]) |-> $past(pwm_rise[g]));
    end
  endgenerate

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gap_zero) |-> ($countones(en_q ^ $past(en_q)) <= 1));

  // R5
  gap_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !gap_zero) |-> gap_ok);

  // R2
  keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[0]);
endmodule

// File: rtl/phase_shed_seq.sv
module phase_shed_seq #(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned VID_W      = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VID_W:0]        vid_data,
  input  logic                  vid_valid,
  input  logic [NUM_PHASES-1:0] pwm_rise,
  input  logic                  pwm_tick,
  input  logic [1:0]            cfg_keep,
  input  logic [1:0]            cfg_gap,
  input  logic                  cfg_offset_off,
  input  logic                  step_done,
  output logic [NUM_PHASES-1:0] phase_en,
  output logic                  step_req,
  output logic [VID_W-1:0]      step_vid,
  output logic                  offset_en,
  output logic                  busy
);
  import psq_pkg::*;

  localparam logic [NUM_PHASES-1:0] ALL = '1;

  logic                  ps_goal, step_pend, all_on, step_evt, gap_ok, gap_zero;
  logic [NUM_PHASES-1:0] keep_mask, goal_mask;
  logic [1:0]            keep_n;

  always_comb begin
    keep_n = keep_count(cfg_keep);
    for (int i = 0; i < NUM_PHASES; i++)
      keep_mask[i] = (i < int'(keep_n));
    goal_mask = ps_goal ? keep_mask : ALL;
  end

  psq_req_ctrl #(.VID_W(VID_W)) req_i (
    .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_valid(vid_valid),
    .all_on(all_on), .step_done(step_done), .ps_goal(ps_goal),
    .step_req(step_req), .step_pend(step_pend), .step_vid(step_vid)
  );

  psq_gap_timer gap_i (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .pwm_tick(pwm_tick),
    .step_evt(step_evt), .gap_ok(gap_ok), .gap_zero(gap_zero)
  );

  psq_phase_ctrl #(.NUM_PHASES(NUM_PHASES)) ph_i (
    .clk(clk), .rst_n(rst_n), .goal_mask(goal_mask), .pwm_rise(pwm_rise),
    .gap_zero(gap_zero), .gap_ok(gap_ok), .phase_en(phase_en),
    .step_evt(step_evt), .all_on(all_on)
  );

  assign offset_en = !(cfg_offset_off && ps_goal);
  assign busy      = (phase_en != goal_mask) || step_pend;

  // R9
  step_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (phase_en == ALL));

  // R11
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !vid_valid) |=> $stable(phase_en));
endmodule

// File: tb/phase_shed_seq_tb_top.sv
module phase_shed_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vid_data = 8'h80;
  logic       vid_valid = 1'b0;
  logic [3:0] pwm_rise = '0;
  logic       pwm_tick = 1'b0;
  logic [1:0] cfg_keep = 2'b10;
  logic [1:0] cfg_gap = 2'b01;
  logic       cfg_offset_off = 1'b0;
  logic       step_done = 1'b0;
  logic [3:0] phase_en;
  logic       step_req, offset_en, busy;
  logic [6:0] step_vid;

  always #4 clk = ~clk;

  phase_shed_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_valid(vid_valid),
    .pwm_rise(pwm_rise), .pwm_tick(pwm_tick), .cfg_keep(cfg_keep),
    .cfg_gap(cfg_gap), .cfg_offset_off(cfg_offset_off), .step_done(step_done),
    .phase_en(phase_en), .step_req(step_req), .step_vid(step_vid),
    .offset_en(offset_en), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // event log filled by the monitor
  int ev_n = 0;
  int ev_idx [128];
  bit ev_off [128];
  int ev_gap [128];
  int ev_cyc [128];
  int ticks_since = 0;
  int cyc = 0;
  int align_viol = 0, step_viol = 0, steps = 0, sc = 0;
  logic [3:0] prev_en = 4'hF;

  // monitor first, then drive the PWM model and stepping unit for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwm_tick) ticks_since++;
      for (int i = 0; i < 4; i++)
        if (phase_en[i] != prev_en[i]) begin
          if (!pwm_rise[i]) align_viol++;
          if (ev_n < 128) begin
            ev_idx[ev_n] = i;
            ev_off[ev_n] = !phase_en[i];
            ev_gap[ev_n] = ticks_since;
            ev_cyc[ev_n] = cyc;
            ev_n++;
          end
        end
      if (phase_en != prev_en) ticks_since = 0;
      if (step_req && phase_en != 4'hF) step_viol++;
      if (step_done) begin
        step_done = 1'b0;
        sc = 0;
      end else if (step_req) begin
        sc++;
        if (sc == 4) begin
          step_done = 1'b1;
          steps++;
        end
      end
    end
    prev_en = phase_en;
    cyc++;
    pwm_tick = (cyc % 8 == 0);
    for (int i = 0; i < 4; i++) pwm_rise[i] = (cyc % 8 == 2 * i);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_vid(input logic [7:0] b);
    @(negedge clk);
    vid_data  = b;
    vid_valid = 1'b1;
    @(negedge clk);
    vid_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    repeat (2) @(negedge clk);
    while ((busy || step_req) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(t < 2000, "R11 idle timeout", t, 0);
  endtask

  function automatic int exp_keep(input logic [1:0] k);
    return (k == 2'b00) ? 2 : int'(k);
  endfunction

  function automatic int exp_gap(input logic [1:0] g);
    return (g == 2'b11) ? 4 : int'(g);
  endfunction

  // {keep, gap, offset_off}
  localparam logic [4:0] VEC [6] = '{
    {2'b01, 2'b01, 1'b0}, {2'b10, 2'b00, 1'b1}, {2'b11, 2'b10, 1'b0},
    {2'b01, 2'b11, 1'b1}, {2'b00, 2'b01, 1'b0}, {2'b01, 2'b00, 1'b0}
  };

  // checks order, gaps and span over log entries [b, ev_n)
  task automatic chk_seq(input int b, input bit shed, input int first, input int g);
    if (g == 0) begin
      chk((ev_cyc[ev_n-1] - ev_cyc[b]) < 8, "R6 span", ev_cyc[ev_n-1] - ev_cyc[b], 7);
    end else begin
      chk(ev_idx[b] == first, shed ? "R3 first shed" : "R7 first restore", ev_idx[b], first);
      for (int k = b + 1; k < ev_n; k++) begin
        chk(ev_idx[k] == (shed ? ev_idx[k-1] - 1 : ev_idx[k-1] + 1),
            shed ? "R3 order" : "R7 order", ev_idx[k], ev_idx[k-1]);
        chk(ev_gap[k] >= g && ev_gap[k] <= g + 1, "R5 gap", ev_gap[k], g);
      end
    end
    for (int k = b; k < ev_n; k++)
      chk(ev_off[k] == shed, shed ? "R3 direction" : "R7 direction", ev_off[k], shed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase_en == 4'hF, "R1 phase_en", phase_en, 4'hF);
    chk(!busy && !step_req, "R1 busy/step_req", {busy, step_req}, 0);
    chk(offset_en, "R1 offset_en", offset_en, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 first code with normal request: step raised, phases untouched
    send_vid(8'hA0);
    wait_idle();
    chk(steps == 1, "R8 step count", steps, 1);
    chk(step_vid == 7'h20, "R8 step_vid", step_vid, 7'h20);
    chk(phase_en == 4'hF, "R8 phases", phase_en, 4'hF);

    foreach (VEC[v]) begin
      int b, kp, g, em;
      cfg_keep       = VEC[v][4:3];
      cfg_gap        = VEC[v][2:1];
      cfg_offset_off = VEC[v][0];
      kp = exp_keep(cfg_keep);
      g  = exp_gap(cfg_gap);
      em = (1 << kp) - 1;
      b  = ev_n;
      send_vid(8'h20);
      chk(busy, "R11 busy on request", busy, 1);
      wait_idle();
      chk(phase_en == 4'(em), "R2 kept mask", phase_en, em);
      chk(ev_n - b == 4 - kp, "R3 shed count", ev_n - b, 4 - kp);
      if (ev_n > b) chk_seq(b, 1'b1, 3, g);
      chk(offset_en == !cfg_offset_off, "R10 offset in mode", offset_en, !cfg_offset_off);
      b = ev_n;
      send_vid(8'hA0);
      wait_idle();
      chk(phase_en == 4'hF, "R7 restored", phase_en, 4'hF);
      if (ev_n > b) chk_seq(b, 1'b0, kp, g);
      chk(offset_en, "R10 offset normal", offset_en, 1);
    end

    // R12 reversal during a shed
    begin
      int b, t;
      cfg_keep = 2'b01;
      cfg_gap  = 2'b10;
      b = ev_n;
      t = 0;
      send_vid(8'h20);
      while (phase_en != 4'b0111 && t < 500) begin
        @(negedge clk);
        t++;
      end
      send_vid(8'hA0);
      wait_idle();
      chk(phase_en == 4'hF, "R12 restored", phase_en, 4'hF);
      chk(ev_n - b == 2, "R12 event count", ev_n - b, 2);
    end

    // R9 code change while in low-power mode
    begin
      int b, s0;
      cfg_keep = 2'b10;
      cfg_gap  = 2'b01;
      send_vid(8'h20);
      wait_idle();
      b  = ev_n;
      s0 = steps;
      send_vid(8'h30);
      wait_idle();
      chk(steps == s0 + 1, "R9 step count", steps, s0 + 1);
      chk(step_vid == 7'h30, "R9 step_vid", step_vid, 7'h30);
      chk(phase_en == 4'b0011, "R9 re-entered", phase_en, 4'b0011);
      chk(ev_n - b == 4, "R9 event count", ev_n - b, 4);
      chk(!ev_off[b] && !ev_off[b+1], "R9 restore first", {ev_off[b], ev_off[b+1]}, 0);
      chk(ev_off[b+2] && ev_off[b+3], "R9 shed after step", {ev_off[b+2], ev_off[b+3]}, 3);
      chk(step_viol == 0, "R9 step with phases off", step_viol, 0);
      send_vid(8'hB1);
      wait_idle();
      chk(phase_en == 4'hF && step_vid == 7'h31, "R8 normal step", {phase_en, step_vid}, {4'hF, 7'h31});
    end

    chk(align_viol == 0, "R4 pwm alignment", align_viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule